// File: doc/BRIEF.md
# Indirect Memory Bit-Test Execution Unit

This unit executes a non-destructive bit test on a 4-bit data path. A 13-bit instruction word picks one of two 4-bit data registers (A or B, supplied on input ports) and one of two 16-bit index registers (X or Y, held inside the unit). The unit drives the indexed address to data memory and ANDs the returned 4-bit word with the chosen data register. Only the zero flag records the result. The unit has no write path to memory. A post-increment variant steps the chosen index register by one after the test and leaves the flags alone.

A one-shot extension state (an 8-bit value plus a pending bit) is loaded through a separate port by the preceding prefix instruction. When the pending bit is set, the plain form of the test ignores the index value. Its address is then forced into a 256-word page: the bottom page when the index is X, the top page when the index is Y. The post-increment form ignores the extension. Any executed test consumes the pending bit, and each test completes in a single clock cycle. Index registers can be loaded through a dedicated write port, so the surrounding core can set up pointers.

Top module: `bittest_unit`

## Requirements
- R1: `exec_strobe` is high in a cycle exactly when `instr_valid` is 1 and `instr[12:3]` equals 10'b1101011101 (codes 1AE8H to 1AEFH). The address is driven in that same cycle.
- R2: Instruction field positions: `instr[2]` selects the data register (0 = A, 1 = B), `instr[1]` selects the index register (0 = X, 1 = Y), and `instr[0]` selects post-increment (0 = none, 1 = increment).
- R3: On the clock edge that ends an executing cycle, `z_flag` becomes 1 if the selected data register ANDed with `mem_rdata` is 4'b0000, and 0 otherwise.
- R4: When the extension is not pending, `mem_addr` equals the selected index register.
- R5: When the extension is pending, the form is plain and the index is X, `mem_addr` is 0000H plus the 8-bit extension value.
- R6: When the extension is pending, the form is plain and the index is Y, `mem_addr` is FF00H plus the 8-bit extension value.
- R7: The post-increment form uses the plain index address even when the extension is pending. After the test it adds 1 to the selected index register modulo 2^16, so FFFFH wraps to 0000H.
- R8: Post-increment changes only the selected index register. The new `z_flag` is the test result whatever the increment produces.
- R9: `ext_pending` clears after any executed test. If `ext_load` is high in the same cycle, the new load wins: pending is set and the new value is kept.
- R10: A cycle with no execution leaves `z_flag`, the index registers and the extension state unchanged (apart from `ext_load` and index writes). This covers an invalid cycle and a non-matching code.
- R11: An index write in the same cycle as a post-increment of the same register takes priority: the register takes the written value.
- R12: After reset, `z_flag` = 0, both index registers = 0000H and `ext_pending` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 13 | Instruction word |
| reg_a | input | 4 | Data register A |
| reg_b | input | 4 | Data register B |
| mem_rdata | input | 4 | Data memory word at `mem_addr` (combinational read) |
| ext_load | input | 1 | Load the extension value and set pending |
| ext_data | input | 8 | Extension value |
| idx_wr_en | input | 1 | Index register write enable |
| idx_wr_sel | input | 1 | Index register to write (0 = X, 1 = Y) |
| idx_wr_data | input | 16 | Index write value |
| exec_strobe | output | 1 | A bit test executes this cycle |
| mem_addr | output | 16 | Effective data memory address |
| z_flag | output | 1 | Zero flag |
| x_idx | output | 16 | Index register X |
| y_idx | output | 16 | Index register Y |
| ext_pending | output | 1 | Extension is armed for the next test |

## Verification
Two pairs of functions can collide in one cycle. A test consuming the extension can meet a fresh extension load, and a post-increment can meet an index write to the same register. Directed steps force each collision. The random stream also produces both at random, because it mixes extension loads and index writes with executing codes. Each outcome is judged against the bench's reference model, which applies the stated priorities: the new load survives the consumption, and the write beats the increment.

// File: rtl/bt_pkg.sv
// Package: shared widths, the opcode pattern and the decoded instruction
// type for the bit-test unit. Assumes a 4-bit data path with 16-bit indices.
package bt_pkg;
    localparam int DATA_W  = 4;
    localparam int ADDR_W  = 16;
    localparam int EXT_W   = 8;
    localparam int INSTR_W = 13;
    localparam int OPC_W   = INSTR_W - 3;
    localparam logic [OPC_W-1:0] BT_OPCODE = 10'b1101011101;

    typedef struct packed {
        logic hit;
        logic use_b;
        logic use_y;
        logic post_inc;
    } bt_dec_t;
endpackage

// File: rtl/bt_decode.sv
// Module: bt_decode
// Decodes the instruction word into a hit strobe and the three selector
// fields. Assumes the opcode sits in the top bits above three field bits.
module bt_decode
    import bt_pkg::*;
(
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    output bt_dec_t            dec
);
    // Match the fixed pattern and split out the field bits.
    always_comb begin
        dec.hit      = instr_valid && (instr[INSTR_W-1:3] == BT_OPCODE);
        dec.use_b    = instr[2];
        dec.use_y    = instr[1];
        dec.post_inc = instr[0];
    end
endmodule

// File: rtl/bt_addr_gen.sv
// Module: bt_addr_gen
// Forms the effective address: the plain index value, or a forced page
// address (bottom page for X, top page for Y) when the extension is pending
// and the form does not post-increment. Purely combinational.
module bt_addr_gen
    import bt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int EW = EXT_W
) (
    input  bt_dec_t          dec,
    input  logic [AW-1:0]    x_val,
    input  logic [AW-1:0]    y_val,
    input  logic             ext_pend,
    input  logic [EW-1:0]    ext_val,
    output logic [AW-1:0]    addr
);
    localparam int PAGE_HI_W = AW - EW;

    logic [AW-1:0] plain_addr;
    logic          use_page;

    // Choose the plain index and decide whether the page override applies.
    always_comb begin
        plain_addr = dec.use_y ? y_val : x_val;
        use_page   = ext_pend && !dec.post_inc;
    end

    // Build the page address; upper bits are all zeros for X, all ones for Y.
    always_comb begin
        if (use_page)
            addr = {{PAGE_HI_W{dec.use_y}}, ext_val};
        else
            addr = plain_addr;
    end
endmodule

// File: rtl/bt_index_regs.sv
// Module: bt_index_regs
// Holds the index registers. Each can be loaded through the write port
// or stepped by one after a post-increment test; the write has priority.
module bt_index_regs
    import bt_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int N_IDX  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  bt_dec_t                  dec,
    input  logic                     wr_en,
    input  logic [$clog2(N_IDX)-1:0] wr_sel,
    input  logic [AW-1:0]            wr_data,
    output logic [N_IDX-1:0][AW-1:0] idx_q
);
    localparam int SEL_W = $clog2(N_IDX);

    for (genvar g = 0; g < N_IDX; g++) begin : g_idx
        logic inc_en;
        logic wr_hit;

        // Work out whether this register is written or stepped this cycle.
        always_comb begin
            inc_en = dec.hit && dec.post_inc && (SEL_W'(dec.use_y) == SEL_W'(g));
            wr_hit = wr_en && (wr_sel == SEL_W'(g));
        end

        // Update the register: reset, write, then modulo-2^AW increment.
        always_ff @(posedge clk) begin
            if (!rst_n)
                idx_q[g] <= '0;
            else if (wr_hit)
                idx_q[g] <= wr_data;
            else if (inc_en)
                idx_q[g] <= idx_q[g] + AW'(1);
        end
    end
endmodule

// File: rtl/bt_ext_state.sv
// Module: bt_ext_state
// One-shot extension state. A load arms it with a new value; any executed
// test disarms it; a load in the same cycle wins over the disarm.
module bt_ext_state
    import bt_pkg::*;
#(
    parameter int EW = EXT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [EW-1:0] load_val,
    input  logic          consume,
    output logic          pend_q,
    output logic [EW-1:0] val_q
);
    // Arm, disarm and hold the extension pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (load)
            pend_q <= 1'b1;
        else if (consume)
            pend_q <= 1'b0;
    end

    // Capture the extension value on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val_q <= '0;
        else if (load)
            val_q <= load_val;
    end
endmodule

// File: rtl/bittest_unit.sv
// Module: bittest_unit (top)
// Executes the indirect bit test in one cycle: decode, address, AND with the
// selected data register, zero-flag update, optional index step and
// extension consumption. Assumes data memory answers combinationally.
module bittest_unit
    import bt_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int EW = EXT_W,
    parameter int IW = INSTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [IW-1:0] instr,
    input  logic [DW-1:0] reg_a,
    input  logic [DW-1:0] reg_b,
    input  logic [DW-1:0] mem_rdata,
    input  logic          ext_load,
    input  logic [EW-1:0] ext_data,
    input  logic          idx_wr_en,
    input  logic          idx_wr_sel,
    input  logic [AW-1:0] idx_wr_data,
    output logic          exec_strobe,
    output logic [AW-1:0] mem_addr,
    output logic          z_flag,
    output logic [AW-1:0] x_idx,
    output logic [AW-1:0] y_idx,
    output logic          ext_pending
);
    bt_dec_t          dec;
    logic [1:0][AW-1:0] idx_q;
    logic [EW-1:0]    ext_val;
    logic [DW-1:0]    test_res;

    bt_decode u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .dec         (dec)
    );

    bt_ext_state #(.EW(EW)) u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ext_load),
        .load_val (ext_data),
        .consume  (dec.hit),
        .pend_q   (ext_pending),
        .val_q    (ext_val)
    );

    bt_index_regs #(.AW(AW), .N_IDX(2)) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .wr_en   (idx_wr_en),
        .wr_sel  (idx_wr_sel),
        .wr_data (idx_wr_data),
        .idx_q   (idx_q)
    );

    bt_addr_gen #(.AW(AW), .EW(EW)) u_addr (
        .dec      (dec),
        .x_val    (idx_q[0]),
        .y_val    (idx_q[1]),
        .ext_pend (ext_pending),
        .ext_val  (ext_val),
        .addr     (mem_addr)
    );

    // Expose the strobe and the index registers.
    always_comb begin
        exec_strobe = dec.hit;
        x_idx       = idx_q[0];
        y_idx       = idx_q[1];
    end

    // AND the selected data register with the memory word.
    always_comb begin
        test_res = (dec.use_b ? reg_b : reg_a) & mem_rdata;
    end

    // Record the zero result on an executing cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            z_flag <= 1'b0;
        else if (dec.hit)
            z_flag <= (test_res == '0);
    end
endmodule

// File: rtl/bittest_checker.sv
// Module: bittest_checker
// Property checks on the bit-test unit's ports, attached by bind below.
module bittest_checker #(
    parameter int DW = 4,
    parameter int AW = 16,
    parameter int EW = 8,
    parameter int IW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_valid,
    input logic [IW-1:0] instr,
    input logic [DW-1:0] reg_a,
    input logic [DW-1:0] reg_b,
    input logic [DW-1:0] mem_rdata,
    input logic          ext_load,
    input logic          idx_wr_en,
    input logic          idx_wr_sel,
    input logic          exec_strobe,
    input logic [AW-1:0] mem_addr,
    input logic          z_flag,
    input logic [AW-1:0] x_idx,
    input logic [AW-1:0] y_idx,
    input logic          ext_pending
);
    localparam logic [IW-4:0] OPC = 10'b1101011101;

    assert_strobe_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        exec_strobe |-> (instr_valid && instr[IW-1:3] == OPC));

    assert_z_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && exec_strobe) |=>
            z_flag == ((($past(instr[2]) ? $past(reg_b) : $past(reg_a)) & $past(mem_rdata)) == '0));

    assert_page_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_strobe && ext_pending && !instr[0] && !instr[1]) |-> (mem_addr[AW-1:EW] == '0));

    assert_page_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_strobe && ext_pending && !instr[0] && instr[1]) |-> (&mem_addr[AW-1:EW]));

    assert_x_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && exec_strobe && instr[0] && !instr[1] && !(idx_wr_en && !idx_wr_sel))
            |=> x_idx == $past(x_idx) + AW'(1));

    assert_y_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && exec_strobe && instr[0] && instr[1] && !(idx_wr_en && idx_wr_sel))
            |=> y_idx == $past(y_idx) + AW'(1));

    assert_ext_consume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && exec_strobe && !ext_load) |=> !ext_pending);

    assert_z_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !exec_strobe) |=> $stable(z_flag));
endmodule

bind bittest_unit bittest_checker #(.DW(DW), .AW(AW), .EW(EW), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .reg_a       (reg_a),
    .reg_b       (reg_b),
    .mem_rdata   (mem_rdata),
    .ext_load    (ext_load),
    .idx_wr_en   (idx_wr_en),
    .idx_wr_sel  (idx_wr_sel),
    .exec_strobe (exec_strobe),
    .mem_addr    (mem_addr),
    .z_flag      (z_flag),
    .x_idx       (x_idx),
    .y_idx       (y_idx),
    .ext_pending (ext_pending)
);

// File: tb/test_bittest_unit.sv
`timescale 1ns/1ps
module test_bittest_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [12:0] instr;
    logic [3:0]  reg_a, reg_b, mem_rdata;
    logic        ext_load;
    logic [7:0]  ext_data;
    logic        idx_wr_en, idx_wr_sel;
    logic [15:0] idx_wr_data;
    logic        exec_strobe;
    logic [15:0] mem_addr, x_idx, y_idx;
    logic        z_flag, ext_pending;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mx, my;
    logic        mz, me;
    logic [7:0]  mext;

    always #5 clk = ~clk;

    function automatic logic [3:0] mem_of(input logic [15:0] a);
        return a[3:0] ^ a[7:4] ^ a[11:8] ^ a[15:12] ^ 4'h9;
    endfunction

    assign mem_rdata = mem_of(mem_addr);

    bittest_unit i_bittest_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .reg_a(reg_a), .reg_b(reg_b), .mem_rdata(mem_rdata),
        .ext_load(ext_load), .ext_data(ext_data),
        .idx_wr_en(idx_wr_en), .idx_wr_sel(idx_wr_sel), .idx_wr_data(idx_wr_data),
        .exec_strobe(exec_strobe), .mem_addr(mem_addr), .z_flag(z_flag),
        .x_idx(x_idx), .y_idx(y_idx), .ext_pending(ext_pending)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(input logic [12:0] c);
        if (me && !c[0]) return c[1] ? {8'hFF, mext} : {8'h00, mext};
        return c[1] ? my : mx;
    endfunction

    // One cycle: drive at negedge, check combinational outputs, then state.
    task automatic step(input bit v, input logic [12:0] c, input logic [3:0] a, input logic [3:0] b,
                        input bit el, input logic [7:0] ed, input bit we, input bit ws,
                        input logic [15:0] wd, input string tag);
        bit hit;
        logic [15:0] ea;
        string atag;
        instr_valid = v; instr = c; reg_a = a; reg_b = b;
        ext_load = el; ext_data = ed; idx_wr_en = we; idx_wr_sel = ws; idx_wr_data = wd;
        #1;
        hit = v && (c[12:3] == 10'b1101011101);
        check(exec_strobe == hit, "R1 strobe", 64'(exec_strobe), 64'(hit));
        ea = exp_addr(c);
        if (hit) begin
            atag = (me && !c[0]) ? (c[1] ? "R6 page Y" : "R5 page X") : (c[0] ? "R7 plain addr" : "R4 plain addr");
            check(mem_addr == ea, atag, 64'(mem_addr), 64'(ea));
            mz = (((c[2] ? b : a) & mem_of(ea)) == 4'h0);
            if (c[0]) begin
                if (c[1]) my = my + 16'd1; else mx = mx + 16'd1;
            end
            me = 1'b0;
        end
        if (we) begin
            if (ws) my = wd; else mx = wd;
        end
        if (el) begin
            me = 1'b1; mext = ed;
        end
        @(negedge clk);
        check({z_flag, x_idx, y_idx, ext_pending} == {mz, mx, my, me}, tag,
              64'({z_flag, x_idx, y_idx, ext_pending}), 64'({mz, mx, my, me}));
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; instr_valid = 1'b0; instr = '0; reg_a = '0; reg_b = '0;
        ext_load = 1'b0; ext_data = '0; idx_wr_en = 1'b0; idx_wr_sel = 1'b0; idx_wr_data = '0;
        mx = '0; my = '0; mz = 1'b0; me = 1'b0; mext = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check({z_flag, x_idx, y_idx, ext_pending} == 34'b0, "R12 reset state",
              64'({z_flag, x_idx, y_idx, ext_pending}), 64'd0);

        // Directed: load pointers, plain tests on A/B, X/Y (R2, R3, R4).
        step(0, 13'h0, 0, 0, 0, 0, 1, 0, 16'h1234, "R11 write X");
        step(0, 13'h0, 0, 0, 0, 0, 1, 1, 16'hABCD, "R11 write Y");
        step(1, 13'h1AE8, 4'hF, 4'h0, 0, 0, 0, 0, 0, "R2 R3 A with X");
        step(1, 13'h1AEC, 4'hF, 4'h0, 0, 0, 0, 0, 0, "R2 R3 B zero result");
        step(1, 13'h1AEA, 4'h0, 4'hF, 0, 0, 0, 0, 0, "R2 R3 A with Y zero");
        // Extension paths (R5, R6, R9).
        step(0, 13'h0, 0, 0, 1, 8'h3C, 0, 0, 0, "R9 ext load");
        step(1, 13'h1AE8, 4'hF, 4'hF, 0, 0, 0, 0, 0, "R5 R9 ext X consumed");
        step(0, 13'h0, 0, 0, 1, 8'hC5, 0, 0, 0, "R9 ext load");
        step(1, 13'h1AEE, 4'hF, 4'hF, 0, 0, 0, 0, 0, "R6 R9 ext Y consumed");
        // Extension ignored by post-increment, still consumed (R7).
        step(0, 13'h0, 0, 0, 1, 8'h77, 0, 0, 0, "R9 ext load");
        step(1, 13'h1AE9, 4'hF, 4'hF, 0, 0, 0, 0, 0, "R7 R9 post-inc ignores ext");
        // Collision: new load with consuming test (R9).
        step(0, 13'h0, 0, 0, 1, 8'h11, 0, 0, 0, "R9 ext load");
        step(1, 13'h1AE8, 4'hF, 4'hF, 1, 8'h22, 0, 0, 0, "R9 load wins over consume");
        step(1, 13'h1AEA, 4'hF, 4'hF, 0, 0, 0, 0, 0, "R6 uses new ext value");
        // Wrap (R7) and single-register step (R8).
        step(0, 13'h0, 0, 0, 0, 0, 1, 0, 16'hFFFF, "R11 write X");
        step(1, 13'h1AED, 4'h0, 4'hF, 0, 0, 0, 0, 0, "R7 R8 X wraps, Y untouched");
        step(1, 13'h1AEB, 4'hF, 4'h0, 0, 0, 0, 0, 0, "R8 Y steps, X untouched");
        // Write beats increment (R11).
        step(1, 13'h1AE9, 4'hF, 4'hF, 0, 0, 1, 0, 16'h0500, "R11 write over inc");
        // Non-execution leaves state (R10).
        step(0, 13'h0, 0, 0, 1, 8'h5A, 0, 0, 0, "R9 ext load");
        step(0, 13'h1AE8, 4'hF, 4'hF, 0, 0, 0, 0, 0, "R10 invalid matching code");
        step(1, 13'h1AF0, 4'hF, 4'hF, 0, 0, 0, 0, 0, "R10 non-matching code");
        step(1, 13'h1AE7, 4'h0, 4'h0, 0, 0, 0, 0, 0, "R10 code just below range");

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            logic [12:0] c;
            c = ($urandom % 5 == 0) ? 13'($urandom) : (13'h1AE8 | 13'($urandom % 8));
            step(($urandom % 8) != 0, c, 4'($urandom), 4'($urandom),
                 ($urandom % 4) == 0, 8'($urandom),
                 ($urandom % 8) == 0, 1'($urandom), 16'($urandom),
                 "R3 R7 R9 R10 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule